// File: doc/BRIEF.md
# Shared-Address Burst SRAM Access Arbiter

This block sits in front of a burst SRAM that has a dedicated read data path and a dedicated write data path but only one address bus. On every rising clock edge it samples an active-low read select, an active-low write select and the address. It then decides whether that edge starts a read burst, a write burst or nothing. The chosen address is captured into a read address register or a write address register.

A burst of four words occupies two clock cycles. For that reason a request of the same kind as the access started on the previous edge is dropped.

When both selects are active on one edge, the winner depends on what was started one edge earlier. After an idle edge the read wins. After a read the write wins. After a write the read wins. Holding both selects low therefore gives a strictly alternating stream that opens with a read.

The outputs are a start-read strobe, a start-write strobe and the two latched addresses, which feed the burst datapaths. Each strobe is high for the one cycle that follows the accepting edge.

Top module: `sram_arb_top`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, both strobes are 0 and both latched addresses are 0.
- R2: The selects are active low and are sampled only on the rising clock edge. A lone read select (rd_sel_ni=0) or a lone write select (wr_sel_ni=0) after an idle edge raises the matching strobe for exactly the cycle after that edge.
- R3: A read request on the edge right after an accepted read is ignored, so start_rd_o is never high on two consecutive cycles.
- R4: A write request on the edge right after an accepted write is ignored, so start_wr_o is never high on two consecutive cycles.
- R5: When both selects are active and the previous edge started nothing, a read is started.
- R6: When both selects are active and the previous edge started a read, a write is started.
- R7: When both selects are active and the previous edge started a write, a read is started.
- R8: Holding both selects active from idle produces read, write, read, write and so on, starting with a read.
- R9: A latched address keeps its value on every edge that does not accept an access of its own kind. This holds whatever addr_i carries and whatever the other port does.
- R10: start_rd_o and start_wr_o are never high together.
- R11: On an accepted access, the matching latched address equals addr_i as sampled on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_ni | input | 1 | Read port select, active low |
| wr_sel_ni | input | 1 | Write port select, active low |
| addr_i | input | ADDR_W | Shared address bus |
| start_rd_o | output | 1 | One-cycle pulse: read burst started |
| start_wr_o | output | 1 | One-cycle pulse: write burst started |
| rd_addr_o | output | ADDR_W | Address of the latest accepted read |
| wr_addr_o | output | ADDR_W | Address of the latest accepted write |

## Verification
The hardest state to reach is a contested edge whose winner is set by history. Both selects must be low right after a lone write, right after a lone read and right after an idle edge. Each of these needs a specific lead-in, followed by a change of address on the losing port.

Directed sequences build each lead-in explicitly. A random phase then biases both selects low often enough that all three histories recur many times. On every cycle the bench compares the outputs with a reference model of the history state kept in bench functions.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
  typedef enum logic [1:0] {
    H_IDLE = 2'd0,
    H_RD   = 2'd1,
    H_WR   = 2'd2
  } hist_e;
endpackage

// File: rtl/sram_arb_decide.sv
module sram_arb_decide
  import sram_arb_pkg::*;
(
  input  hist_e hist_i,
  input  logic  rd_req_i,
  input  logic  wr_req_i,
  output hist_e next_o
);
  logic rd_ok, wr_ok;

  assign rd_ok = rd_req_i && (hist_i != H_RD);
  assign wr_ok = wr_req_i && (hist_i != H_WR);

  always_comb begin
    next_o = H_IDLE;
    if (rd_ok && wr_ok)  next_o = H_RD;   // both allowed only from idle: read first
    else if (rd_ok)      next_o = H_RD;
    else if (wr_ok)      next_o = H_WR;
  end
endmodule

// File: rtl/sram_arb_hist.sv
module sram_arb_hist
  import sram_arb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_req_i,
  input  logic  wr_req_i,
  input  hist_e next_i,
  output hist_e hist_o,
  output logic  start_rd_o,
  output logic  start_wr_o
);
  hist_e hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= H_IDLE;
    else         hist_q <= next_i;
  end

  assign hist_o     = hist_q;
  assign start_rd_o = (hist_q == H_RD);
  assign start_wr_o = (hist_q == H_WR);

  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_rd_o && start_wr_o));
  // R3
  no_rd_b2b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rd_o |=> !start_rd_o);
  // R4
  no_wr_b2b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_o |=> !start_wr_o);
  // R6
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rd_o && rd_req_i && wr_req_i) |=> start_wr_o);
  // R7
  rd_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_o && rd_req_i && wr_req_i) |=> start_rd_o);
  // R5
  rd_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_rd_o && !start_wr_o && rd_req_i) |=> start_rd_o);
endmodule

// File: rtl/sram_arb_addr_reg.sv
module sram_arb_addr_reg #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= d_i;
  end

  assign q_o = q;

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  // R11
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/sram_arb_top.sv
module sram_arb_top
  import sram_arb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              start_rd_o,
  output logic              start_wr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  localparam int NPORT = 2;

  logic  rd_req, wr_req;
  hist_e hist, next;
  logic  [NPORT-1:0]             load;
  logic  [NPORT-1:0][ADDR_W-1:0] q;

  assign rd_req = !rd_sel_ni;
  assign wr_req = !wr_sel_ni;

  sram_arb_decide u_decide (
    .hist_i  (hist),
    .rd_req_i(rd_req),
    .wr_req_i(wr_req),
    .next_o  (next)
  );

  sram_arb_hist u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_req_i  (rd_req),
    .wr_req_i  (wr_req),
    .next_i    (next),
    .hist_o    (hist),
    .start_rd_o(start_rd_o),
    .start_wr_o(start_wr_o)
  );

  assign load[0] = (next == H_RD);
  assign load[1] = (next == H_WR);

  for (genvar g = 0; g < NPORT; g++) begin : g_areg
    sram_arb_addr_reg #(.W(ADDR_W)) u_areg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load[g]),
      .d_i   (addr_i),
      .q_o   (q[g])
    );
  end

  assign rd_addr_o = q[0];
  assign wr_addr_o = q[1];

  // R2
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_ni && wr_sel_ni) |=> (!start_rd_o && !start_wr_o));
endmodule

// File: tb/sim_sram_arb_top.sv
`timescale 1ns/1ps
module sim_sram_arb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          s_rd, s_wr;
  logic [AW-1:0] rd_a, wr_a;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model: 0 idle, 1 read last, 2 write last
  int            m_hist = 0;
  logic [AW-1:0] m_rd_a = '0, m_wr_a = '0;

  always #2.5 clk = ~clk;

  sram_arb_top #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_sel_ni(rd_sel_n), .wr_sel_ni(wr_sel_n),
    .addr_i(addr), .start_rd_o(s_rd), .start_wr_o(s_wr),
    .rd_addr_o(rd_a), .wr_addr_o(wr_a)
  );

  function automatic int next_kind(int h, bit rq, bit wq);
    bit rok = rq && (h != 1);
    bit wok = wq && (h != 2);
    if (rok) return 1;
    if (wok) return 2;
    return 0;
  endfunction

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " start_rd"}, AW'(s_rd), AW'(m_hist == 1));
    chk({tag, " start_wr"}, AW'(s_wr), AW'(m_hist == 2));
    chk({tag, " rd_addr"}, rd_a, m_rd_a);
    chk({tag, " wr_addr"}, wr_a, m_wr_a);
  endtask

  // drive after negedge, clock once, update model, check at next negedge
  task automatic step(bit rq, bit wq, logic [AW-1:0] a, string tag);
    int nk;
    rd_sel_n = !rq; wr_sel_n = !wq; addr = a;
    @(posedge clk);
    nk = next_kind(m_hist, rq, wq);
    if (nk == 1) m_rd_a = a;
    if (nk == 2) m_wr_a = a;
    m_hist = nk;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5a17));
    @(negedge clk);
    check_all("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    step(1, 0, 20'h00011, "R2 lone read");
    step(0, 0, 20'h0ff00, "R2 idle");
    step(0, 1, 20'h00022, "R2 lone write");
    step(0, 0, 20'h00000, "R9 idle hold");
    step(1, 0, 20'h00031, "R3 first read");
    step(1, 0, 20'h00032, "R3 b2b read ignored");
    step(1, 0, 20'h00033, "R11 read after gap");
    step(0, 0, 20'h0, "idle");
    step(0, 1, 20'h00041, "R4 first write");
    step(0, 1, 20'h00042, "R4 b2b write ignored");
    step(0, 0, 20'h0, "idle");
    step(1, 1, 20'h00051, "R5 both from idle");
    step(0, 0, 20'h0, "idle");
    step(1, 0, 20'h00061, "R6 lead read");
    step(1, 1, 20'h00062, "R6 both after read");
    step(0, 0, 20'h0, "idle");
    step(0, 1, 20'h00071, "R7 lead write");
    step(1, 1, 20'h00072, "R7 both after write");
    step(0, 0, 20'h0, "idle");
    for (int i = 0; i < 8; i++)
      step(1, 1, AW'(20'h00080 + i), "R8 alternate");
    step(0, 0, 20'h0, "idle");
    step(0, 1, 20'h000a1, "R9 write only");
    step(0, 0, 20'hfffff, "R9 deselected addr");
    step(1, 0, 20'h000b1, "R9 read leaves wr addr");

    for (int i = 0; i < 2000; i++) begin
      int r = $urandom_range(0, 9);
      bit rq = (r < 6);
      bit wq = (r >= 3 && r < 9);
      step(rq, wq, AW'($urandom()), "R10 R11 random");
    end

    rst_n = 1'b0;
    m_hist = 0; m_rd_a = '0; m_wr_a = '0;
    @(negedge clk);
    check_all("R1 mid-run reset");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule